// File: doc/BRIEF.md
# Indexed Clock Register File

This block is the host-facing register file of a real-time clock. The host reaches a 128-byte space through two addresses. A write to the even address picks a byte index. Reads and writes at the odd address then go to the byte that index selects. The space holds four control registers (A to D), the time and date bytes, the alarm bytes and general storage.

The time counter and the periodic-rate generator sit outside this block. They drive strobes into it:
- flag strobes for update-ended, alarm and periodic events;
- start and end of an update cycle.

The block drives back to them:
- the decoded control fields;
- an interrupt line;
- a one-cycle load strobe that tells the time counter to take the host's new time.

The block enforces the rules of the control registers:
- The update-in-progress bit cannot be written by the host.
- The SET bit blocks updates and clears the update interrupt enable.
- Register C clears itself when it is read, and that read drops the interrupt line.

Top module: `cmos_regfile`

## Requirements
- R1: A host write at the even address (`addr_sel`=0) stores `wdata` AND 0x7F as the index. Odd-address accesses (`addr_sel`=1) read or write the byte at that index.
- R2: A read at the even address returns 0xFF.
- R3: After reset, register A (index 10) is 0x26, B (index 11) is 0x02, C (index 12) is 0x00 and D (index 13) is 0x80. `irq` and `load_stb` are low.
- R4: Bit 7 of register A (update in progress) is read-only. A host write to A changes only bits 6:0.
- R5: A host write to register B with bit 7 (SET) at 1 stores bit 4 as 0 and clears bit 7 of register A.
- R6: Host writes to register C and register D leave them unchanged.
- R7: Strobe `uf_set` sets C bit 4, `af_set` sets C bit 5 and `pf_set` sets C bit 6. C bit 7 and `irq` go high when a strobe arrives while its enable is set. The enables are B bit 4 for `uf_set`, B bit 5 for `af_set` and B bit 6 for `pf_set`. `irq` always equals C bit 7.
- R8: A read of register C returns its current value. In the next cycle C is 0x00 and `irq` is low.
- R9: A flag strobe in the same cycle as a read of C survives the clear: the read returns the old value, and the new flag (with bit 7, if its enable is set) is present afterwards.
- R10: `load_stb` is high for one cycle after either of these writes:
  - a write to a time byte (index 0, 2, 4, 6, 7, 8 or 9) while B bit 7 is 0;
  - a write to B with bit 7 at 0 while B bit 7 was 1.
- R11: `uip_set` sets A bit 7 only while B bit 7 is 0. `uip_clr` clears it.
- R12: All other indices (alarm bytes 1, 3, 5 and indices 14 to 127) are plain read/write bytes, reset to 0x00.
- R13: The field outputs follow the registers:
  - `rate_sel` = A[3:0] and `div_ctl` = A[6:4];
  - `set_mode`, `per_ie`, `alm_ie`, `upd_ie`, `sqw_en`, `bin_mode`, `hr24` and `dst_en` = B bits 7 down to 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cs | input | 1 | Chip select |
| addr_sel | input | 1 | 0 selects the index address, 1 selects the data address |
| rd_stb | input | 1 | Host read strobe |
| wr_stb | input | 1 | Host write strobe |
| wdata | input | 8 | Host write data |
| uf_set | input | 1 | Update-ended flag strobe |
| af_set | input | 1 | Alarm flag strobe |
| pf_set | input | 1 | Periodic flag strobe |
| uip_set | input | 1 | Update cycle start |
| uip_clr | input | 1 | Update cycle end |
| rdata | output | 8 | Read data, valid in the cycle of the read strobe |
| rate_sel | output | 4 | Periodic rate select |
| div_ctl | output | 3 | Oscillator divider control |
| set_mode | output | 1 | Time updates halted |
| per_ie | output | 1 | Periodic interrupt enable |
| alm_ie | output | 1 | Alarm interrupt enable |
| upd_ie | output | 1 | Update-ended interrupt enable |
| sqw_en | output | 1 | Square-wave enable |
| bin_mode | output | 1 | Binary (not BCD) data mode |
| hr24 | output | 1 | 24-hour mode |
| dst_en | output | 1 | Daylight-saving enable |
| irq | output | 1 | Interrupt request |
| load_stb | output | 1 | Time counter load pulse |

## Verification
Two pairs of events can land in the same cycle. The first is a host read of register C together with a flag strobe from the time or periodic logic. The second is a host write to register B that raises SET together with an update-start strobe. Directed cases place a strobe exactly in the read cycle of C. They check that the returned byte carries only the old flags, and that the new flag, with bit 7 when enabled, is still there afterwards. A long random phase issues index, data and strobe traffic in the same cycles, so both pairs occur many times. A cycle-level model in the bench judges every read, the interrupt line, the load pulse and the field outputs.

// File: rtl/cmos_pkg.sv
package cmos_pkg;
    localparam int DATA_W = 8;

    // Control register indices (decoded by neighbouring logic)
    localparam int IDX_CTRL_A = 10;
    localparam int IDX_CTRL_B = 11;
    localparam int IDX_CTRL_C = 12;
    localparam int IDX_CTRL_D = 13;

    // Register B bit positions
    localparam int B_SET  = 7;
    localparam int B_PIE  = 6;
    localparam int B_AIE  = 5;
    localparam int B_UIE  = 4;

    // Register C bit positions
    localparam int C_IRQF = 7;
    localparam int C_PF   = 6;
    localparam int C_AF   = 5;
    localparam int C_UF   = 4;

    localparam logic [DATA_W-1:0] RST_A = 8'h26;
    localparam logic [DATA_W-1:0] RST_B = 8'h02;
    localparam logic [DATA_W-1:0] RST_C = 8'h00;
    localparam logic [DATA_W-1:0] VAL_D = 8'h80;

    typedef struct packed {
        logic              uip;
        logic [6:0]        a_low;
        logic [DATA_W-1:0] b;
        logic [DATA_W-1:0] c;
        logic              load;
    } ctrl_state_t;

    function automatic logic is_time_idx(input int unsigned idx);
        return (idx == 0) || (idx == 2) || (idx == 4) ||
               (idx >= 6 && idx <= 9);
    endfunction
endpackage

// File: rtl/cmos_host_if.sv
module cmos_host_if #(
    parameter int IDX_W = 7
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cs,
    input  logic             addr_sel,
    input  logic             rd_stb,
    input  logic             wr_stb,
    input  logic [7:0]       wdata,
    output logic [IDX_W-1:0] idx,
    output logic             data_wr,
    output logic             data_rd,
    output logic             index_rd
);
    logic [IDX_W-1:0] idx_d, idx_q;
    logic             index_wr;

    always_comb begin
        index_wr = cs && wr_stb && !addr_sel;
        data_wr  = cs && wr_stb && addr_sel;
        data_rd  = cs && rd_stb && addr_sel;
        index_rd = cs && rd_stb && !addr_sel;
        idx_d    = idx_q;
        if (index_wr) idx_d = wdata[IDX_W-1:0];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) idx_q <= '0;
        else        idx_q <= idx_d;
    end

    assign idx = idx_q;

    // R1
    index_latch_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cs && wr_stb && !addr_sel) |=> (idx == $past(wdata[IDX_W-1:0])));
endmodule

// File: rtl/cmos_ctrl_regs.sv
module cmos_ctrl_regs
    import cmos_pkg::*;
#(
    parameter int IDX_W = 7
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [IDX_W-1:0]  idx,
    input  logic              data_wr,
    input  logic              data_rd,
    input  logic [DATA_W-1:0] wdata,
    input  logic              uf_set,
    input  logic              af_set,
    input  logic              pf_set,
    input  logic              uip_set,
    input  logic              uip_clr,
    output logic              ctrl_hit,
    output logic [DATA_W-1:0] ctrl_byte,
    output logic [DATA_W-1:0] reg_a,
    output logic [DATA_W-1:0] reg_b,
    output logic              irq,
    output logic              load_stb
);
    ctrl_state_t d, q;
    logic hit_a, hit_b, hit_c, hit_d, time_hit, raise;

    always_comb begin
        hit_a    = (idx == IDX_W'(IDX_CTRL_A));
        hit_b    = (idx == IDX_W'(IDX_CTRL_B));
        hit_c    = (idx == IDX_W'(IDX_CTRL_C));
        hit_d    = (idx == IDX_W'(IDX_CTRL_D));
        ctrl_hit = hit_a || hit_b || hit_c || hit_d;
        time_hit = is_time_idx(int'(idx));
        raise    = (uf_set && q.b[B_UIE]) || (af_set && q.b[B_AIE]) ||
                   (pf_set && q.b[B_PIE]);

        d      = q;
        d.load = 1'b0;

        // register A: host owns bits 6:0 only
        if (data_wr && hit_a) d.a_low = wdata[6:0];
        if (uip_set && !q.b[B_SET]) d.uip = 1'b1;
        if (uip_clr) d.uip = 1'b0;

        // register B with the SET interlock
        if (data_wr && hit_b) begin
            if (wdata[B_SET]) begin
                d.b   = wdata & ~(8'h01 << B_UIE);
                d.uip = 1'b0;
            end else begin
                d.b = wdata;
                if (q.b[B_SET]) d.load = 1'b1;
            end
        end

        if (data_wr && time_hit && !q.b[B_SET]) d.load = 1'b1;

        // register C: clear on read, new flags win
        if (data_rd && hit_c) d.c = '0;
        if (uf_set) d.c[C_UF] = 1'b1;
        if (af_set) d.c[C_AF] = 1'b1;
        if (pf_set) d.c[C_PF] = 1'b1;
        if (raise)  d.c[C_IRQF] = 1'b1;

        unique case (1'b1)
            hit_a:   ctrl_byte = {q.uip, q.a_low};
            hit_b:   ctrl_byte = q.b;
            hit_c:   ctrl_byte = q.c;
            hit_d:   ctrl_byte = VAL_D;
            default: ctrl_byte = '0;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q.uip   <= RST_A[7];
            q.a_low <= RST_A[6:0];
            q.b     <= RST_B;
            q.c     <= RST_C;
            q.load  <= 1'b0;
        end else begin
            q <= d;
        end
    end

    assign reg_a    = {q.uip, q.a_low};
    assign reg_b    = q.b;
    assign irq      = q.c[C_IRQF];
    assign load_stb = q.load;

    // R4
    a_ro_bit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (data_wr && hit_a && !uip_set && !uip_clr) |=> (reg_a[7] == $past(reg_a[7])));
    // R5
    set_interlock_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (data_wr && hit_b && wdata[B_SET]) |=> (!reg_b[B_UIE] && !reg_a[7]));
    // R8
    c_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (data_rd && hit_c && !uf_set && !af_set && !pf_set) |=> (ctrl_byte == 8'h00 || !hit_c) && !irq);
    // R9
    flag_survive_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (data_rd && hit_c && uf_set) |=> $past(uf_set) && (ctrl_byte[C_UF] || !hit_c));
    // R10
    time_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (data_wr && time_hit && !reg_b[B_SET]) |=> load_stb);
    // R11
    uip_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_b[B_SET] && !reg_a[7]) |=> !reg_a[7]);
endmodule

// File: rtl/cmos_byte_store.sv
module cmos_byte_store
    import cmos_pkg::*;
#(
    parameter int IDX_W = 7
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [IDX_W-1:0]  idx,
    input  logic              we,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rd_byte
);
    localparam int NUM_BYTES = 1 << IDX_W;

    logic [DATA_W-1:0] mem_d [NUM_BYTES];
    logic [DATA_W-1:0] mem_q [NUM_BYTES];

    always_comb begin
        for (int i = 0; i < NUM_BYTES; i++) mem_d[i] = mem_q[i];
        if (we) mem_d[idx] = wdata;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < NUM_BYTES; i++) mem_q[i] <= '0;
        end else begin
            for (int i = 0; i < NUM_BYTES; i++) mem_q[i] <= mem_d[i];
        end
    end

    assign rd_byte = mem_q[idx];

    // R12
    store_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        we |=> (rd_byte == $past(wdata)));
endmodule

// File: rtl/cmos_regfile.sv
module cmos_regfile
    import cmos_pkg::*;
#(
    parameter int IDX_W = 7
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       cs,
    input  logic       addr_sel,
    input  logic       rd_stb,
    input  logic       wr_stb,
    input  logic [7:0] wdata,
    input  logic       uf_set,
    input  logic       af_set,
    input  logic       pf_set,
    input  logic       uip_set,
    input  logic       uip_clr,
    output logic [7:0] rdata,
    output logic [3:0] rate_sel,
    output logic [2:0] div_ctl,
    output logic       set_mode,
    output logic       per_ie,
    output logic       alm_ie,
    output logic       upd_ie,
    output logic       sqw_en,
    output logic       bin_mode,
    output logic       hr24,
    output logic       dst_en,
    output logic       irq,
    output logic       load_stb
);
    logic [IDX_W-1:0]  idx;
    logic              data_wr, data_rd, index_rd, ctrl_hit;
    logic [DATA_W-1:0] ctrl_byte, store_byte, reg_a, reg_b;

    cmos_host_if #(.IDX_W(IDX_W)) host_i (
        .clk(clk), .rst_n(rst_n), .cs(cs), .addr_sel(addr_sel),
        .rd_stb(rd_stb), .wr_stb(wr_stb), .wdata(wdata), .idx(idx),
        .data_wr(data_wr), .data_rd(data_rd), .index_rd(index_rd)
    );

    cmos_ctrl_regs #(.IDX_W(IDX_W)) ctrl_i (
        .clk(clk), .rst_n(rst_n), .idx(idx), .data_wr(data_wr),
        .data_rd(data_rd), .wdata(wdata), .uf_set(uf_set), .af_set(af_set),
        .pf_set(pf_set), .uip_set(uip_set), .uip_clr(uip_clr),
        .ctrl_hit(ctrl_hit), .ctrl_byte(ctrl_byte), .reg_a(reg_a),
        .reg_b(reg_b), .irq(irq), .load_stb(load_stb)
    );

    cmos_byte_store #(.IDX_W(IDX_W)) store_i (
        .clk(clk), .rst_n(rst_n), .idx(idx), .we(data_wr && !ctrl_hit),
        .wdata(wdata), .rd_byte(store_byte)
    );

    always_comb begin
        if (index_rd)     rdata = 8'hFF;
        else if (data_rd) rdata = ctrl_hit ? ctrl_byte : store_byte;
        else              rdata = 8'h00;
    end

    assign rate_sel = reg_a[3:0];
    assign div_ctl  = reg_a[6:4];
    assign {set_mode, per_ie, alm_ie, upd_ie, sqw_en, bin_mode, hr24, dst_en} = reg_b;

    // R2
    even_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cs && rd_stb && !addr_sel) |-> (rdata == 8'hFF));
    // R7
    irq_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (uf_set && upd_ie) |=> irq);
endmodule

// File: tb/cmos_regfile_tb.sv
module cmos_regfile_tb_top;
    logic clk = 1'b0, rst_n = 1'b0;
    logic cs = 0, addr_sel = 0, rd_stb = 0, wr_stb = 0;
    logic [7:0] wdata = 0;
    logic uf_set = 0, af_set = 0, pf_set = 0, uip_set = 0, uip_clr = 0;
    logic [7:0] rdata;
    logic [3:0] rate_sel;
    logic [2:0] div_ctl;
    logic set_mode, per_ie, alm_ie, upd_ie, sqw_en, bin_mode, hr24, dst_en, irq, load_stb;

    int n_chk = 0, n_fail = 0;

    always #10 clk = ~clk;

    cmos_regfile dut_i (.*);

    // bench model
    logic [7:0] m_mem [128];
    logic [7:0] m_a, m_b, m_c;
    logic [6:0] m_idx;
    logic       m_load;

    function automatic logic time_byte(input logic [6:0] i);
        return (i == 0) || (i == 2) || (i == 4) || (i >= 6 && i <= 9);
    endfunction

    function automatic logic [7:0] exp_read(input logic a0);
        if (!a0) return 8'hFF;
        case (m_idx)
            7'd10: return m_a;
            7'd11: return m_b;
            7'd12: return m_c;
            7'd13: return 8'h80;
            default: return m_mem[m_idx];
        endcase
    endfunction

    function automatic string tag_for(input logic a0);
        if (!a0) return "R2";
        case (m_idx)
            7'd10: return "R4";
            7'd11: return "R5";
            7'd12: return "R8";
            7'd13: return "R6";
            default: return "R12";
        endcase
    endfunction

    task automatic check(input string req, input logic [7:0] got, input logic [7:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s: got 0x%02h expected 0x%02h at %0t", req, got, exp, $time);
        end
    endtask

    task automatic cyc(input logic c, a0, rd, wr, input logic [7:0] wd,
                       input logic uf, af, pf, us, uc, input string req);
        logic [7:0] na, nb, nc;
        logic nl;
        @(negedge clk);
        cs = c; addr_sel = a0; rd_stb = rd; wr_stb = wr; wdata = wd;
        uf_set = uf; af_set = af; pf_set = pf; uip_set = us; uip_clr = uc;
        #1;
        if (c && rd) check(req == "" ? tag_for(a0) : req, rdata, exp_read(a0));
        @(posedge clk);
        na = m_a; nb = m_b; nc = m_c; nl = 1'b0;
        if (us && !m_b[7]) na[7] = 1'b1;
        if (uc) na[7] = 1'b0;
        if (c && wr && a0) begin
            case (m_idx)
                7'd10: na[6:0] = wd[6:0];
                7'd11: if (wd[7]) begin nb = wd & 8'hEF; na[7] = 1'b0; end
                       else begin nb = wd; if (m_b[7]) nl = 1'b1; end
                7'd12, 7'd13: ;
                default: begin
                    m_mem[m_idx] = wd;
                    if (time_byte(m_idx) && !m_b[7]) nl = 1'b1;
                end
            endcase
        end
        if (c && rd && a0 && m_idx == 7'd12) nc = 8'h00;
        if (uf) nc[4] = 1'b1;
        if (af) nc[5] = 1'b1;
        if (pf) nc[6] = 1'b1;
        if ((uf && m_b[4]) || (af && m_b[5]) || (pf && m_b[6])) nc[7] = 1'b1;
        if (c && wr && !a0) m_idx = wd[6:0];
        m_a = na; m_b = nb; m_c = nc; m_load = nl;
        #1;
        check("R7", {7'd0, irq}, {7'd0, m_c[7]});
        check("R10", {7'd0, load_stb}, {7'd0, m_load});
        check("R13", {1'b0, div_ctl, rate_sel}, {1'b0, m_a[6:0]});
        check("R13", {set_mode, per_ie, alm_ie, upd_ie, sqw_en, bin_mode, hr24, dst_en}, m_b);
    endtask

    task automatic set_idx(input logic [7:0] i);
        cyc(1, 0, 0, 1, i, 0, 0, 0, 0, 0, "R1");
    endtask
    task automatic wr_dat(input logic [7:0] v);
        cyc(1, 1, 0, 1, v, 0, 0, 0, 0, 0, "");
    endtask
    task automatic rd_dat(input string req);
        cyc(1, 1, 1, 0, 8'h00, 0, 0, 0, 0, 0, req);
    endtask
    task automatic strobe(input logic uf, af, pf, us, uc);
        cyc(0, 0, 0, 0, 8'h00, uf, af, pf, us, uc, "R7");
    endtask

    initial begin
        #(20 * 200000);
        n_chk++; n_fail++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        int unsigned seed;
        seed = $urandom(32'd1357);
        for (int i = 0; i < 128; i++) m_mem[i] = 8'h00;
        m_a = 8'h26; m_b = 8'h02; m_c = 8'h00; m_idx = 0; m_load = 0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        #1;
        // R3 reset state at the ports
        check("R3", {7'd0, irq}, 8'h00);
        check("R3", {7'd0, load_stb}, 8'h00);
        set_idx(8'd10); rd_dat("R3");
        set_idx(8'd11); rd_dat("R3");
        set_idx(8'd12); rd_dat("R3");
        set_idx(8'd13); rd_dat("R3");
        cyc(1, 0, 1, 0, 8'h00, 0, 0, 0, 0, 0, "R2");
        // R1 index masked to 7 bits
        set_idx(8'hC5); wr_dat(8'h5A);
        set_idx(8'h45); rd_dat("R1");
        // R12 alarm byte storage
        set_idx(8'd3); wr_dat(8'hC3); rd_dat("R12");
        // R4 / R11 update-in-progress bit
        set_idx(8'd10); strobe(0, 0, 0, 1, 0);
        wr_dat(8'h00); rd_dat("R4");
        strobe(0, 0, 0, 0, 1); rd_dat("R11");
        // R5 SET interlock, then R11 blocked set
        strobe(0, 0, 0, 1, 0);
        set_idx(8'd11); wr_dat(8'h92); rd_dat("R5");
        set_idx(8'd10); rd_dat("R5");
        strobe(0, 0, 0, 1, 0); rd_dat("R11");
        // R10 time write under SET: no load; clearing SET: load
        set_idx(8'd0); wr_dat(8'h59);
        set_idx(8'd11); wr_dat(8'h72);
        set_idx(8'd2); wr_dat(8'h30); rd_dat("R10");
        // R6 writes to C and D ignored
        set_idx(8'd12); wr_dat(8'hFF); rd_dat("R6");
        set_idx(8'd13); wr_dat(8'h00); rd_dat("R6");
        // R7 / R8 flags and clear on read
        strobe(1, 0, 0, 0, 0);
        strobe(0, 1, 0, 0, 0);
        set_idx(8'd12); rd_dat("R8"); rd_dat("R8");
        // R9 strobe in the same cycle as the read of C
        strobe(0, 0, 1, 0, 0);
        cyc(1, 1, 1, 0, 8'h00, 1, 0, 0, 0, 0, "R9");
        rd_dat("R9");
        cyc(1, 1, 1, 0, 8'h00, 0, 1, 1, 0, 0, "R9");
        rd_dat("R9");
        // random traffic
        for (int k = 0; k < 4000; k++) begin
            logic c, a0, rd, wr;
            logic [7:0] wd;
            int unsigned op;
            op = $urandom_range(0, 9);
            c  = ($urandom_range(0, 9) != 0);
            a0 = (op >= 3);
            rd = (op >= 3 && op <= 6) || op == 0;
            wr = !rd;
            wd = $urandom_range(0, 255);
            if (!a0 && wr && $urandom_range(0, 3) != 0) wd = $urandom_range(0, 15);
            cyc(c, a0, rd, wr, wd,
                ($urandom_range(0, 9) == 0), ($urandom_range(0, 9) == 0),
                ($urandom_range(0, 9) == 0), ($urandom_range(0, 9) == 0),
                ($urandom_range(0, 9) == 0), "");
        end
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule